// File: doc/BRIEF.md
# Command-Byte Register Target on a Two-Wire Bus

This block is an I2C target for bus rates up to 400 kHz. It samples SCL and SDA in the system clock domain and answers one 7-bit device address. Behind it is a small register file that holds sensor control settings: the enable bits, integration and wait times, a pair of 16-bit thresholds, persistence, configuration and gain. It also serves read-only views of an identity byte, a status byte and two 16-bit conversion results.

A write transfer opens with a command byte, which is marked by bit 7. The command either sets the register pointer together with its access mode, or it fires a special function. The pointer survives from one transfer to the next. A later read, or a write whose first byte has bit 7 clear, continues from the stored pointer. Reading the low byte of a result freezes that result's upper byte in a shadow holding register, so a two-byte read cannot mix the halves of two conversions. The only data path is the bus itself, and SCL paces every byte. The register side takes each byte in a single cycle, so there is no valid/ready pair and no back-pressure at the edge of the block. All control and status pins are plain levels, except the one-cycle interrupt-clear pulse.

Top module: `i2c_cmd_regif`

## Requirements
- R1: The target drives an ACK only for its own 7-bit address (parameter, default 0x39). Any other address gets no ACK, and the rest of that transfer changes nothing.
- R2: In a write, a first data byte with bit 7 = 1 is a command. Bits 6:5 are the mode and bits 4:0 are the register pointer or the function code.
- R3: Mode 00 (fixed) makes every following data byte, read or written, access the same register.
- R4: Mode 01 (stepping) advances the pointer by one after each data byte. The 5-bit pointer wraps from 0x1F to 0x00.
- R5: Mode 11 with code 00110 makes `int_clr_o` high for exactly one cycle and leaves the pointer unchanged. Mode 11 with any other code, and mode 10 with any code, change neither the pointer nor the outputs.
- R6: The pointer and the mode are kept across transfers. A read with no command reads at the stored pointer. A write whose first byte has bit 7 = 0 stores that byte at the stored pointer.
- R7: Reading address 0x14 (or 0x16) copies bits 15:8 of result 0 (or result 1) into the shadow register. A read of 0x15 or 0x17 returns the shadow value, even if the result input changed in between.
- R8: After reset, address 0x01 (integration time) and 0x03 (wait time) hold 0xFF, and all other storage holds 0x00. The writable bits are: 0x00 bits 6,4,3,1,0; 0x01, 0x03 and 0x04–0x07 all bits; 0x0C bits 3:0; 0x0D bits 2:1; 0x0F bits 1:0. The other bits read as 0.
- R9: Writes to read-only or unmapped addresses are acknowledged but have no effect. Address 0x12 reads the identity byte (default 0x34). Address 0x13 reads `stat_i` masked to bits 4 and 0. Unmapped addresses read 0x00.
- R10: Each control output matches its register. Each 16-bit threshold takes its low byte from the lower address: low threshold at 0x04/0x05, high threshold at 0x06/0x07. Control outputs change only in the cycle after a data byte is accepted.
- R11: When the controller NACKs a read byte, the target releases SDA and drives nothing more until the next START. The target changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (ACK or a 0 data bit) |
| res0_i | input | 16 | Conversion result 0 |
| res1_i | input | 16 | Conversion result 1 |
| stat_i | input | 8 | Status flags (bits 4 and 0 visible) |
| int_clr_o | output | 1 | One-cycle interrupt-clear pulse |
| ctl_enable_o | output | 8 | Enable register |
| ctl_itime_o | output | 8 | Integration time register |
| ctl_wtime_o | output | 8 | Wait time register |
| ctl_thr_lo_o | output | 16 | Low threshold |
| ctl_thr_hi_o | output | 16 | High threshold |
| ctl_pers_o | output | 4 | Persistence count code |
| ctl_config_o | output | 8 | Configuration register |
| ctl_gain_o | output | 2 | Gain select |

## Verification
The assertions check four properties on every cycle:
- the clear pulse is one cycle wide and only ever follows an accepted byte;
- the control outputs stay stable when no byte was accepted;
- SDA drive changes only while SCL is low;
- byte acceptance and read loading never happen in the same cycle.

Only the bench scenarios can show the properties that depend on command history:
- pointer persistence across transfers;
- stepping and wrap-around;
- that the shadow value survives a change of the result input;
- that ignored modes and foreign addresses leave the state untouched, which the bench checks by reading that state back over the bus.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_AACK, LK_WR, LK_WACK, LK_RD, LK_RACK
  } link_st_t;

  localparam logic [1:0] MODE_FIXED   = 2'b00;
  localparam logic [1:0] MODE_STEP    = 2'b01;
  localparam logic [1:0] MODE_SPECIAL = 2'b11;
  localparam logic [4:0] FN_INT_CLR   = 5'b00110;

  localparam int PTR_W     = 5;
  localparam int CFG_SLOTS = 16;

  localparam logic [PTR_W-1:0] A_IDENT = 5'h12;
  localparam logic [PTR_W-1:0] A_STAT  = 5'h13;
  localparam logic [PTR_W-1:0] A_R0LO  = 5'h14;
  localparam logic [PTR_W-1:0] A_R0HI  = 5'h15;
  localparam logic [PTR_W-1:0] A_R1LO  = 5'h16;
  localparam logic [PTR_W-1:0] A_R1HI  = 5'h17;
  localparam logic [7:0]       STAT_VISIBLE = 8'h11;

  // writable bits per storage slot; zero means no storage at that address
  function automatic logic [7:0] slot_mask(input int a);
    case (a)
      0:                 return 8'h5B;
      1, 3, 4, 5, 6, 7:  return 8'hFF;
      12:                return 8'h0F;
      13:                return 8'h06;
      15:                return 8'h03;
      default:           return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slot_reset(input int a);
    return (a == 1 || a == 3) ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/i2c_cmd_link.sv
module i2c_cmd_link
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic       wr_first_o,
  output logic [7:0] wr_data_o,
  output logic       rd_take_o,
  input  logic [7:0] rd_data_i
);

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  link_st_t st;
  logic [7:0] sh;
  logic [2:0] cnt;
  logic full, rw_q, first_q, nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      {scl_m, scl_s, scl_q} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_q} <= {sda_i, sda_m, sda_s};
    end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  assign wr_data_o = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE; sh <= '0; cnt <= '0; full <= 1'b0;
      rw_q <= 1'b0; first_q <= 1'b0; nack_q <= 1'b0;
      sda_oe_o <= 1'b0; wr_stb_o <= 1'b0; wr_first_o <= 1'b0; rd_take_o <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      rd_take_o <= 1'b0;
      if (bus_start) begin
        st <= LK_ADDR; cnt <= '0; full <= 1'b0; sda_oe_o <= 1'b0;
      end else if (bus_stop) begin
        st <= LK_IDLE; sda_oe_o <= 1'b0;
      end else begin
        case (st)
          LK_ADDR, LK_WR: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              cnt  <= cnt + 3'd1;
              full <= (cnt == 3'd7);
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (st == LK_WR) begin
                sda_oe_o <= 1'b1; wr_stb_o <= 1'b1;
                wr_first_o <= first_q; first_q <= 1'b0;
                st <= LK_WACK;
              end else if (sh[7:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1; rw_q <= sh[0]; st <= LK_AACK;
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          LK_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              sh <= rd_data_i; sda_oe_o <= ~rd_data_i[7];
              rd_take_o <= 1'b1; st <= LK_RD;
            end else begin
              sda_oe_o <= 1'b0; first_q <= 1'b1; st <= LK_WR;
            end
          end
          LK_WACK: if (scl_fall) begin
            sda_oe_o <= 1'b0; cnt <= '0; st <= LK_WR;
          end
          LK_RD: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe_o <= 1'b0; st <= LK_RACK;
            end else begin
              cnt <= cnt + 3'd1; sh <= {sh[6:0], 1'b0}; sda_oe_o <= ~sh[6];
            end
          end
          LK_RACK: begin
            if (scl_rise) nack_q <= sda_s;
            else if (scl_fall) begin
              if (nack_q) st <= LK_IDLE;
              else begin
                cnt <= '0; sh <= rd_data_i; sda_oe_o <= ~rd_data_i[7];
                rd_take_o <= 1'b1; st <= LK_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h34,
  parameter int         RES_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_stb_i,
  input  logic                           wr_first_i,
  input  logic [7:0]                     wr_data_i,
  input  logic                           rd_take_i,
  output logic [7:0]                     rd_data_o,
  input  logic [RES_W-1:0]               res0_i,
  input  logic [RES_W-1:0]               res1_i,
  input  logic [7:0]                     stat_i,
  output logic                           int_clr_o,
  output logic [CFG_SLOTS-1:0][7:0]      slots_o
);

  localparam int HI_LSB = RES_W - 8;

  logic [PTR_W-1:0] ptr_q;
  logic             step_q;
  logic [7:0]       shadow_q;

  logic       is_cmd, data_stb;
  logic [1:0] cmd_mode;
  assign is_cmd   = wr_first_i & wr_data_i[7];
  assign cmd_mode = wr_data_i[6:5];
  assign data_stb = wr_stb_i & ~is_cmd;

  for (genvar g = 0; g < CFG_SLOTS; g++) begin : g_slot
    if (slot_mask(g) != 8'h00) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slots_o[g] <= slot_reset(g);
        else if (data_stb && ptr_q == PTR_W'(g)) slots_o[g] <= wr_data_i & slot_mask(g);
      end
    end else begin : g_none
      assign slots_o[g] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; step_q <= 1'b0; shadow_q <= '0; int_clr_o <= 1'b0;
    end else begin
      int_clr_o <= wr_stb_i & is_cmd & (cmd_mode == MODE_SPECIAL) & (wr_data_i[4:0] == FN_INT_CLR);
      if (wr_stb_i && is_cmd) begin
        if (cmd_mode == MODE_FIXED || cmd_mode == MODE_STEP) begin
          ptr_q  <= wr_data_i[4:0];
          step_q <= cmd_mode[0];
        end
      end else if ((data_stb || rd_take_i) && step_q) begin
        ptr_q <= ptr_q + 1'b1;
      end
      if (rd_take_i && ptr_q == A_R0LO) shadow_q <= res0_i[HI_LSB +: 8];
      if (rd_take_i && ptr_q == A_R1LO) shadow_q <= res1_i[HI_LSB +: 8];
    end
  end

  always_comb begin
    if (!ptr_q[PTR_W-1]) rd_data_o = slots_o[ptr_q[PTR_W-2:0]];
    else begin
      case (ptr_q)
        A_IDENT:         rd_data_o = CHIP_ID;
        A_STAT:          rd_data_o = stat_i & STAT_VISIBLE;
        A_R0LO:          rd_data_o = res0_i[7:0];
        A_R1LO:          rd_data_o = res1_i[7:0];
        A_R0HI, A_R1HI:  rd_data_o = shadow_q;
        default:         rd_data_o = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cmd_regif.sv
module i2c_cmd_regif
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39,
  parameter logic [7:0] CHIP_ID  = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [15:0] res0_i,
  input  logic [15:0] res1_i,
  input  logic [7:0]  stat_i,
  output logic        int_clr_o,
  output logic [7:0]  ctl_enable_o,
  output logic [7:0]  ctl_itime_o,
  output logic [7:0]  ctl_wtime_o,
  output logic [15:0] ctl_thr_lo_o,
  output logic [15:0] ctl_thr_hi_o,
  output logic [3:0]  ctl_pers_o,
  output logic [7:0]  ctl_config_o,
  output logic [1:0]  ctl_gain_o
);

  logic       wr_stb, wr_first, rd_take;
  logic [7:0] wr_data, rd_data;
  logic [CFG_SLOTS-1:0][7:0] slots;

  i2c_cmd_link #(.DEV_ADDR(DEV_ADDR)) link_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
    .wr_stb_o(wr_stb), .wr_first_o(wr_first), .wr_data_o(wr_data),
    .rd_take_o(rd_take), .rd_data_i(rd_data)
  );

  i2c_cmd_regs #(.CHIP_ID(CHIP_ID), .RES_W(16)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_first_i(wr_first),
    .wr_data_i(wr_data), .rd_take_i(rd_take), .rd_data_o(rd_data),
    .res0_i(res0_i), .res1_i(res1_i), .stat_i(stat_i),
    .int_clr_o(int_clr_o), .slots_o(slots)
  );

  assign ctl_enable_o = slots[0];
  assign ctl_itime_o  = slots[1];
  assign ctl_wtime_o  = slots[3];
  assign ctl_thr_lo_o = {slots[5], slots[4]};
  assign ctl_thr_hi_o = {slots[7], slots[6]};
  assign ctl_pers_o   = slots[12][3:0];
  assign ctl_config_o = slots[13];
  assign ctl_gain_o   = slots[15][1:0];

  logic unused_slot_bits;
  assign unused_slot_bits = ^{slots[2], slots[8], slots[9], slots[10], slots[11],
                              slots[12][7:4], slots[14], slots[15][7:2]};

endmodule

// File: rtl/i2c_cmd_regif_chk.sv
module i2c_cmd_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       int_clr_o,
  input logic       wr_stb,
  input logic       rd_take,
  input logic [7:0] ctl_enable_o,
  input logic [7:0] ctl_itime_o
);

  assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_o |=> !int_clr_o);

  assert_clr_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr_o |-> $past(wr_stb));

  assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(ctl_enable_o) && $stable(ctl_itime_o)));

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_take));

endmodule

bind i2c_cmd_regif i2c_cmd_regif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .int_clr_o(int_clr_o), .wr_stb(wr_stb), .rd_take(rd_take),
  .ctl_enable_o(ctl_enable_o), .ctl_itime_o(ctl_itime_o)
);

// File: tb/i2c_cmd_regif_tb.sv
module i2c_cmd_regif_tb_top;

  localparam int         Q   = 8;
  localparam logic [6:0] DEV = 7'h39;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl = 1'b1, tb_low = 1'b0;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = ~(sda_oe | tb_low);

  logic [15:0] res0 = 16'h0, res1 = 16'h0;
  logic [7:0]  stat = 8'h0;
  logic        int_clr;
  logic [7:0]  en, itime, wtime, cfg;
  logic [15:0] thr_lo, thr_hi;
  logic [3:0]  pers;
  logic [1:0]  gain;

  i2c_cmd_regif dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .res0_i(res0), .res1_i(res1), .stat_i(stat), .int_clr_o(int_clr),
    .ctl_enable_o(en), .ctl_itime_o(itime), .ctl_wtime_o(wtime),
    .ctl_thr_lo_o(thr_lo), .ctl_thr_hi_o(thr_hi), .ctl_pers_o(pers),
    .ctl_config_o(cfg), .ctl_gain_o(gain)
  );

  int errs = 0, checks = 0, clr_seen = 0, clr_exp = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n && int_clr) clr_seen++;

  // reference model
  logic [7:0] mslot [16];
  logic [4:0] mptr;
  bit         mstep;
  logic [7:0] mshadow;
  logic [7:0] txbuf [8];

  function automatic logic [7:0] mmask(input int a);
    case (a)
      0: return 8'h5B;
      12: return 8'h0F;
      13: return 8'h06;
      15: return 8'h03;
      1, 3, 4, 5, 6, 7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) mslot[i] = (i == 1 || i == 3) ? 8'hFF : 8'h00;
    mptr = 0; mstep = 0; mshadow = 0;
  endtask

  task automatic m_wbyte(input bit first, input logic [7:0] b);
    if (first && b[7]) begin
      if (b[6:5] == 2'b00 || b[6:5] == 2'b01) begin mptr = b[4:0]; mstep = b[5]; end
      else if (b[6:5] == 2'b11 && b[4:0] == 5'b00110) clr_exp++;
    end else begin
      if (mptr < 16) mslot[mptr] = b & mmask(int'(mptr));
      if (mstep) mptr = mptr + 1;
    end
  endtask

  task automatic m_rbyte(output logic [7:0] e);
    case (mptr)
      5'h12: e = 8'h34;
      5'h13: e = stat & 8'h11;
      5'h14: begin e = res0[7:0]; mshadow = res0[15:8]; end
      5'h16: begin e = res1[7:0]; mshadow = res1[15:8]; end
      5'h15, 5'h17: e = mshadow;
      default: e = (mptr < 16) ? mslot[mptr] : 8'h00;
    endcase
    if (mstep) mptr = mptr + 1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus driver
  task automatic hold(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start();
    tb_low = 1; hold(2*Q); scl = 0;
  endtask
  task automatic b_rstart();
    tb_low = 0; hold(Q); scl = 1; hold(Q); tb_low = 1; hold(Q); scl = 0;
  endtask
  task automatic b_stop();
    hold(Q); tb_low = 1; hold(Q); scl = 1; hold(Q); tb_low = 0; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hold(Q); tb_low = ~b[i]; hold(Q); scl = 1; hold(2*Q); scl = 0;
    end
    hold(Q); tb_low = 0; hold(Q); scl = 1; hold(Q); ack = ~sda_bus; hold(Q); scl = 0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    tb_low = 0;
    for (int i = 7; i >= 0; i--) begin
      hold(2*Q); scl = 1; hold(Q); b[i] = sda_bus; hold(Q); scl = 0;
    end
    hold(Q); tb_low = ack; hold(Q); scl = 1; hold(2*Q); scl = 0; hold(Q); tb_low = 0;
  endtask

  task automatic wr_txn(input int n, input string tag);
    bit a;
    b_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 address ack (write)", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(txbuf[i], a); chk(a, {tag, " data ack"}, a, 1);
      m_wbyte(i == 0, txbuf[i]);
    end
    b_stop();
  endtask

  task automatic rd_body(input int n, input string tag);
    logic [7:0] e, g;
    for (int i = 0; i < n; i++) begin
      m_rbyte(e);
      recv_byte(i != n-1, g);
      chk(g == e, tag, g, e);
    end
    b_stop();
    chk(sda_oe == 1'b0, "R11 released after NACK", sda_oe, 0);
  endtask

  task automatic rd_txn(input int n, input string tag);
    bit a;
    b_start();
    send_byte({DEV, 1'b1}, a); chk(a, "R1 address ack (read)", a, 1);
    rd_body(n, tag);
  endtask

  task automatic cmb_txn(input logic [7:0] cmd, input int n, input string tag);
    bit a;
    b_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 address ack", a, 1);
    send_byte(cmd, a); chk(a, "R2 command ack", a, 1);
    m_wbyte(1, cmd);
    b_rstart();
    send_byte({DEV, 1'b1}, a); chk(a, "R1 address ack (restart)", a, 1);
    rd_body(n, tag);
  endtask

  task automatic port_check(input string tag);
    chk(en == mslot[0], {tag, " enable"}, en, mslot[0]);
    chk(itime == mslot[1], {tag, " itime"}, itime, mslot[1]);
    chk(wtime == mslot[3], {tag, " wtime"}, wtime, mslot[3]);
    chk(thr_lo == {mslot[5], mslot[4]}, {tag, " thr_lo"}, thr_lo, {mslot[5], mslot[4]});
    chk(thr_hi == {mslot[7], mslot[6]}, {tag, " thr_hi"}, thr_hi, {mslot[7], mslot[6]});
    chk(pers == mslot[12][3:0], {tag, " pers"}, pers, mslot[12][3:0]);
    chk(cfg == mslot[13], {tag, " config"}, cfg, mslot[13]);
    chk(gain == mslot[15][1:0], {tag, " gain"}, gain, mslot[15][1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    int n, c0;
    logic [7:0] cmd;
    void'($urandom(32'd20240611));
    m_reset();
    hold(5); rst_n = 1; hold(5);

    // R8 reset state at the ports
    port_check("R8 reset");
    chk(sda_oe == 0 && int_clr == 0, "R8 idle outputs", {sda_oe, int_clr}, 0);

    // R3 R9 identity read twice in fixed mode
    cmb_txn(8'h92, 2, "R3 R9 identity fixed read");

    // R8 reserved bits of enable masked
    txbuf[0] = 8'h80; txbuf[1] = 8'hFF; wr_txn(2, "R8 enable write");
    chk(en == 8'h5B, "R8 enable mask", en, 8'h5B);

    // R4 R10 stepping threshold write and readback
    txbuf[0] = 8'hA4; txbuf[1] = 8'h11; txbuf[2] = 8'h22; txbuf[3] = 8'h33; txbuf[4] = 8'h44;
    wr_txn(5, "R4 stepping write");
    chk(thr_lo == 16'h2211, "R10 low threshold", thr_lo, 16'h2211);
    chk(thr_hi == 16'h4433, "R10 high threshold", thr_hi, 16'h4433);
    cmb_txn(8'hA4, 4, "R4 stepping readback");

    // R6 read without command continues at stored pointer (0x08, unmapped)
    rd_txn(1, "R6 persisted pointer read");
    // R6 write with bit7 clear lands at stored pointer
    txbuf[0] = 8'h8C; wr_txn(1, "R2 set pointer 0x0C");
    txbuf[0] = 8'h57; wr_txn(1, "R6 data-first write");
    chk(pers == 4'h7, "R6 persistence via stored pointer", pers, 4'h7);

    // R5 special functions
    c0 = clr_seen;
    txbuf[0] = 8'hE6; wr_txn(1, "R5 clear command");
    hold(4);
    chk(clr_seen == c0 + 1, "R5 single clear pulse", clr_seen, c0 + 1);
    txbuf[0] = 8'hE0; wr_txn(1, "R5 no-op function");
    txbuf[0] = 8'hC5; wr_txn(1, "R5 reserved mode");
    hold(4);
    chk(clr_seen == c0 + 1, "R5 no extra pulse", clr_seen, c0 + 1);
    rd_txn(1, "R5 pointer unchanged by functions");

    // R1 foreign address gets no ACK and no effect
    b_start(); send_byte({7'h3A, 1'b0}, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h81, a); send_byte(8'h00, a); b_stop();
    chk(itime == mslot[1], "R1 foreign write ignored", itime, mslot[1]);
    rd_txn(1, "R1 pointer kept after foreign address");

    // R9 read-only and unmapped writes ignored, status masked
    txbuf[0] = 8'h92; txbuf[1] = 8'h55; wr_txn(2, "R9 write to identity");
    rd_txn(1, "R9 identity unchanged");
    txbuf[0] = 8'h9A; txbuf[1] = 8'h77; wr_txn(2, "R9 write unmapped");
    rd_txn(1, "R9 unmapped reads zero");
    stat = 8'hFF;
    cmb_txn(8'h93, 1, "R9 status masked");

    // R7 shadow coherence
    res0 = 16'hA1B2; res1 = 16'h0C0D;
    b_start(); send_byte({DEV, 1'b0}, a); send_byte(8'hB4, a); m_wbyte(1, 8'hB4);
    b_rstart(); send_byte({DEV, 1'b1}, a);
    begin
      logic [7:0] g;
      recv_byte(1, g); chk(g == 8'hB2, "R7 low byte", g, 8'hB2);
      res0 = 16'hCCDD;
      recv_byte(0, g); chk(g == 8'hA1, "R7 shadow high byte", g, 8'hA1);
      mptr = 5'h16; mshadow = 8'hA1;
    end
    b_stop();
    rd_txn(2, "R7 result1 pair");

    // R4 wrap from 0x1F to 0x00
    cmb_txn(8'hBF, 2, "R4 pointer wrap");

    // constrained random mix
    for (int it = 0; it < 22; it++) begin
      res0 = 16'($urandom); res1 = 16'($urandom); stat = 8'($urandom);
      cmd = {1'b1, 1'b0, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 23))};
      n = $urandom_range(1, 3);
      txbuf[0] = cmd;
      for (int k = 1; k <= n; k++) txbuf[k] = 8'($urandom);
      wr_txn(n + 1, "R2 random write");
      cmb_txn(cmd, n, "R3 R4 random readback");
    end
    port_check("R10 final ports");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule